// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit for a 32-bit load/store processor whose datapath shares one memory and one ALU between instructions. Each instruction runs over several clock cycles. The sequencer steps through a fixed series of states for each instruction class. In each state it drives the multiplexer selects, ALU operation class and write enables that the datapath needs for that step. It reads the 6-bit opcode field from the instruction register, an overflow flag from the ALU and an illegal-encoding hint from the datapath.

Loads, stores, register-register operations, branch-if-equal and jumps each follow their own path after a shared fetch and decode. There are two exception paths: an undefined encoding seen in decode, and an arithmetic overflow seen at register-register writeback. Either one records a cause code, saves the address of the faulting instruction, switches the core to kernel mode with interrupts off, and redirects the PC to the fixed handler vector. The sequencer then returns to fetch.

Most outputs are Moore outputs: they depend only on the current state. The single exception is the register-file write enable during register-register writeback, which the overflow flag can suppress in the same cycle. The asynchronous active-low reset is released through a two-stage synchronizer. Fetch therefore holds for two clock edges after reset is deasserted.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_n is low, the outputs show the fetch encoding, and this holds even if reset arrives in the middle of an instruction. After rst_n rises, fetch holds for two more rising edges, and decode follows on the third.
- R2: Fetch drives mem_rd=1, addr_sel=0, ir_we=1, alu_a_sel=0, alu_b_sel=01, alu_op=00, pc_we=1 and pc_src=00.
- R3: Decode drives alu_a_sel=0, alu_b_sel=11 and alu_op=00, with every write enable at 0. The next state is chosen by opcode: 0x00 goes to register-register execute, 0x23 and 0x2B go to address calculation, 0x04 goes to branch, and 0x02 goes to jump.
- R4: Address calculation drives alu_a_sel=1, alu_b_sel=10 and alu_op=00. For opcode 0x23 it is followed by a read step (mem_rd=1, addr_sel=1). For opcode 0x2B it is followed by a write step (mem_wr=1, addr_sel=1), and the store then returns to fetch.
- R5: Load writeback drives rf_we=1, dst_sel=0 and wb_sel=1, then returns to fetch.
- R6: Register-register execute drives alu_a_sel=1, alu_b_sel=00 and alu_op=10.
- R7: Register-register writeback with ovf=0 drives rf_we=1, dst_sel=1 and wb_sel=0, then returns to fetch.
- R8: Register-register writeback with ovf=1 holds rf_we at 0 and enters the overflow exception state. That state writes cause code 1.
- R9: Branch drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_we_cond=1, pc_src=01 and pc_we=0, then returns to fetch.
- R10: Jump drives pc_we=1 and pc_src=10, then returns to fetch.
- R11: In decode, any opcode outside the five listed in R3, or ill_hint=1 with any opcode, enters the undefined-instruction exception state. That state writes cause code 0.
- R12: An exception state drives epc_we=1, cause_we=1, pc_we=1, pc_src=11, vec_sel=1, kmode_set=1 and intr_off=1. It also drives alu_a_sel=0, alu_b_sel=01 and alu_op=01, so the ALU forms PC-4. It then returns to fetch.
- R13: Every write enable and select that R2 to R12 do not name for a state is 0 in that state, and mem_rd and mem_wr are never both 1. The ovf input has no effect in any state other than register-register writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| opcode | input | 6 | Opcode field of the instruction register |
| ill_hint | input | 1 | Datapath flags the instruction as illegal |
| ovf | input | 1 | ALU signed overflow flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| ir_we | output | 1 | Instruction register write enable |
| alu_a_sel | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B operand: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write when the ALU reports zero |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 handler vector |
| dst_sel | output | 1 | Destination register: 0 = rt, 1 = rd |
| rf_we | output | 1 | Register file write enable |
| wb_sel | output | 1 | Writeback data: 0 = ALU result, 1 = memory data |
| epc_we | output | 1 | Exception PC register write |
| cause_we | output | 1 | Cause register write |
| cause_code | output | 1 | Cause value: 0 undefined instruction, 1 overflow |
| vec_sel | output | 1 | Handler vector selected onto the PC |
| kmode_set | output | 1 | Switch to kernel mode |
| intr_off | output | 1 | Disable interrupts |

## Verification
The bench looks for an overflow that arrives during writeback. A design that samples ovf one cycle late, or registers the write enable, would commit a bad result to the register file, or would fall through to fetch and never trap. Opcodes that sit next to legal codes, and a legal opcode paired with ill_hint, are run through decode. A decoder that ignored the hint or matched too few bits would start executing garbage instead of vectoring with cause 0. Reset is pulsed in the middle of a load to confirm the asynchronous return to fetch and the two-edge hold. The bench also holds ovf high through load, store, branch and jump, because a design that leaks the flag outside writeback would take false traps.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_MRD    = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MWR    = 4'd5,
    ST_REXE   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BEQ    = 4'd8,
    ST_JMP    = 4'd9,
    ST_XUND   = 4'd10,
    ST_XOVF   = 4'd11
  } state_e;

  typedef enum logic [2:0] {
    OC_RTYPE = 3'd0,
    OC_LOAD  = 3'd1,
    OC_STORE = 3'd2,
    OC_BEQ   = 3'd3,
    OC_JMP   = 3'd4,
    OC_BAD   = 3'd5
  } opcls_e;

  // Select encodings consumed by the datapath multiplexers.
  localparam logic       ASRC_PC    = 1'b0;
  localparam logic       ASRC_REG   = 1'b1;
  localparam logic [1:0] BSRC_REG   = 2'b00;
  localparam logic [1:0] BSRC_FOUR  = 2'b01;
  localparam logic [1:0] BSRC_IMM   = 2'b10;
  localparam logic [1:0] BSRC_BOFF  = 2'b11;
  localparam logic [1:0] ALU_ADD    = 2'b00;
  localparam logic [1:0] ALU_SUB    = 2'b01;
  localparam logic [1:0] ALU_FUNC   = 2'b10;
  localparam logic [1:0] PCS_ALU    = 2'b00;
  localparam logic [1:0] PCS_ALUREG = 2'b01;
  localparam logic [1:0] PCS_JADDR  = 2'b10;
  localparam logic [1:0] PCS_VEC    = 2'b11;
  localparam logic       CAUSE_UND  = 1'b0;
  localparam logic       CAUSE_OVF  = 1'b1;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_we;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       pc_we;
    logic       pc_we_cond;
    logic [1:0] pc_src;
    logic       dst_sel;
    logic       rf_we;
    logic       wb_sel;
    logic       epc_we;
    logic       cause_we;
    logic       cause_code;
    logic       vec_sel;
    logic       kmode_set;
    logic       intr_off;
  } ctrl_t;

endpackage

// File: rtl/mcc_rst_sync.sv
module mcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign srst_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= {sh[STAGES-2:0], 1'b1};
      end
      assign srst_n = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mcc_opdec.sv
module mcc_opdec
  import mcc_pkg::*;
#(
  parameter int unsigned OPC_W  = 6,
  parameter int unsigned OP_R   = 'h00,
  parameter int unsigned OP_LD  = 'h23,
  parameter int unsigned OP_ST  = 'h2B,
  parameter int unsigned OP_BEQ = 'h04,
  parameter int unsigned OP_J   = 'h02
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             ill_hint,
  output opcls_e           cls
);

  always_comb begin
    if (ill_hint)                      cls = OC_BAD;
    else if (opcode == OPC_W'(OP_R))   cls = OC_RTYPE;
    else if (opcode == OPC_W'(OP_LD))  cls = OC_LOAD;
    else if (opcode == OPC_W'(OP_ST))  cls = OC_STORE;
    else if (opcode == OPC_W'(OP_BEQ)) cls = OC_BEQ;
    else if (opcode == OPC_W'(OP_J))   cls = OC_JMP;
    else                               cls = OC_BAD;
  end

endmodule

// File: rtl/mcc_next.sv
module mcc_next
  import mcc_pkg::*;
(
  input  state_e state,
  input  opcls_e cls,
  input  logic   ovf,
  output state_e state_nxt
);

  always_comb begin
    state_nxt = ST_FETCH;
    case (state)
      ST_FETCH:  state_nxt = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          OC_RTYPE: state_nxt = ST_REXE;
          OC_LOAD:  state_nxt = ST_MADDR;
          OC_STORE: state_nxt = ST_MADDR;
          OC_BEQ:   state_nxt = ST_BEQ;
          OC_JMP:   state_nxt = ST_JMP;
          default:  state_nxt = ST_XUND;
        endcase
      end
      // The store/load split re-reads the class, which holds while IR is stable.
      ST_MADDR:  state_nxt = (cls == OC_STORE) ? ST_MWR : ST_MRD;
      ST_MRD:    state_nxt = ST_LDWB;
      ST_LDWB:   state_nxt = ST_FETCH;
      ST_MWR:    state_nxt = ST_FETCH;
      ST_REXE:   state_nxt = ST_RWB;
      ST_RWB:    state_nxt = ovf ? ST_XOVF : ST_FETCH;
      ST_BEQ:    state_nxt = ST_FETCH;
      ST_JMP:    state_nxt = ST_FETCH;
      ST_XUND:   state_nxt = ST_FETCH;
      ST_XOVF:   state_nxt = ST_FETCH;
      default:   state_nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_outdec.sv
module mcc_outdec
  import mcc_pkg::*;
(
  input  state_e state,
  input  logic   ovf,
  output ctrl_t  ctl
);

  always_comb begin
    ctl = '0;
    case (state)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.addr_sel  = 1'b0;
        ctl.ir_we     = 1'b1;
        ctl.alu_a_sel = ASRC_PC;
        ctl.alu_b_sel = BSRC_FOUR;
        ctl.alu_op    = ALU_ADD;
        ctl.pc_we     = 1'b1;
        ctl.pc_src    = PCS_ALU;
      end
      ST_DECODE: begin
        ctl.alu_a_sel = ASRC_PC;
        ctl.alu_b_sel = BSRC_BOFF;
        ctl.alu_op    = ALU_ADD;
      end
      ST_MADDR: begin
        ctl.alu_a_sel = ASRC_REG;
        ctl.alu_b_sel = BSRC_IMM;
        ctl.alu_op    = ALU_ADD;
      end
      ST_MRD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_MWR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_we   = 1'b1;
        ctl.dst_sel = 1'b0;
        ctl.wb_sel  = 1'b1;
      end
      ST_REXE: begin
        ctl.alu_a_sel = ASRC_REG;
        ctl.alu_b_sel = BSRC_REG;
        ctl.alu_op    = ALU_FUNC;
      end
      ST_RWB: begin
        ctl.rf_we   = ~ovf;
        ctl.dst_sel = 1'b1;
        ctl.wb_sel  = 1'b0;
      end
      ST_BEQ: begin
        ctl.alu_a_sel  = ASRC_REG;
        ctl.alu_b_sel  = BSRC_REG;
        ctl.alu_op     = ALU_SUB;
        ctl.pc_we_cond = 1'b1;
        ctl.pc_src     = PCS_ALUREG;
      end
      ST_JMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PCS_JADDR;
      end
      ST_XUND, ST_XOVF: begin
        ctl.alu_a_sel  = ASRC_PC;
        ctl.alu_b_sel  = BSRC_FOUR;
        ctl.alu_op     = ALU_SUB;
        ctl.epc_we     = 1'b1;
        ctl.cause_we   = 1'b1;
        ctl.cause_code = (state == ST_XOVF) ? CAUSE_OVF : CAUSE_UND;
        ctl.pc_we      = 1'b1;
        ctl.pc_src     = PCS_VEC;
        ctl.vec_sel    = 1'b1;
        ctl.kmode_set  = 1'b1;
        ctl.intr_off   = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int unsigned OPC_W       = 6,
  parameter int unsigned OP_R        = 'h00,
  parameter int unsigned OP_LD       = 'h23,
  parameter int unsigned OP_ST       = 'h2B,
  parameter int unsigned OP_BEQ      = 'h04,
  parameter int unsigned OP_J        = 'h02,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             ill_hint,
  input  logic             ovf,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic             ir_we,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             pc_we,
  output logic             pc_we_cond,
  output logic [1:0]       pc_src,
  output logic             dst_sel,
  output logic             rf_we,
  output logic             wb_sel,
  output logic             epc_we,
  output logic             cause_we,
  output logic             cause_code,
  output logic             vec_sel,
  output logic             kmode_set,
  output logic             intr_off
);

  logic   rst_sync_n;
  state_e state_q;
  state_e state_nxt;
  opcls_e cls;
  ctrl_t  ctl;

  mcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  mcc_opdec #(
    .OPC_W(OPC_W), .OP_R(OP_R), .OP_LD(OP_LD),
    .OP_ST(OP_ST), .OP_BEQ(OP_BEQ), .OP_J(OP_J)
  ) u_opdec (
    .opcode   (opcode),
    .ill_hint (ill_hint),
    .cls      (cls)
  );

  mcc_next u_next (
    .state     (state_q),
    .cls       (cls),
    .ovf       (ovf),
    .state_nxt (state_nxt)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_FETCH;
    else             state_q <= state_nxt;
  end

  mcc_outdec u_out (
    .state (state_q),
    .ovf   (ovf),
    .ctl   (ctl)
  );

  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign addr_sel   = ctl.addr_sel;
  assign ir_we      = ctl.ir_we;
  assign alu_a_sel  = ctl.alu_a_sel;
  assign alu_b_sel  = ctl.alu_b_sel;
  assign alu_op     = ctl.alu_op;
  assign pc_we      = ctl.pc_we;
  assign pc_we_cond = ctl.pc_we_cond;
  assign pc_src     = ctl.pc_src;
  assign dst_sel    = ctl.dst_sel;
  assign rf_we      = ctl.rf_we;
  assign wb_sel     = ctl.wb_sel;
  assign epc_we     = ctl.epc_we;
  assign cause_we   = ctl.cause_we;
  assign cause_code = ctl.cause_code;
  assign vec_sel    = ctl.vec_sel;
  assign kmode_set  = ctl.kmode_set;
  assign intr_off   = ctl.intr_off;

endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
  parameter int unsigned OPC_W  = 6,
  parameter int unsigned OP_R   = 'h00,
  parameter int unsigned OP_LD  = 'h23,
  parameter int unsigned OP_ST  = 'h2B,
  parameter int unsigned OP_BEQ = 'h04,
  parameter int unsigned OP_J   = 'h02
) (
  input logic             clk,
  input logic             rst_ok,
  input logic [OPC_W-1:0] opcode,
  input logic             ill_hint,
  input logic             ovf,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             ir_we,
  input logic [1:0]       alu_b_sel,
  input logic             pc_we,
  input logic             pc_we_cond,
  input logic [1:0]       pc_src,
  input logic             dst_sel,
  input logic             rf_we,
  input logic             epc_we,
  input logic             cause_we,
  input logic             cause_code,
  input logic             vec_sel
);

  logic op_known;
  assign op_known = (opcode == OPC_W'(OP_R))  || (opcode == OPC_W'(OP_LD)) ||
                    (opcode == OPC_W'(OP_ST)) || (opcode == OPC_W'(OP_BEQ)) ||
                    (opcode == OPC_W'(OP_J));

  assert_mem_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_ok)
    !(mem_rd && mem_wr));

  assert_decode_follows_fetch_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    ir_we |=> (alu_b_sel == 2'b11 && !pc_we && !ir_we));

  assert_ovf_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (dst_sel && ovf) |-> !rf_we);

  assert_ovf_traps_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (dst_sel && ovf) |=> (cause_we && cause_code));

  assert_undef_traps_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (alu_b_sel == 2'b11 && (ill_hint || !op_known)) |=> (cause_we && !cause_code));

  assert_exc_vector_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    vec_sel |-> (pc_we && pc_src == 2'b11 && epc_we && cause_we));

  assert_exc_returns_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    cause_we |=> ir_we);

  assert_branch_cond_only_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    pc_we_cond |-> (!pc_we && pc_src == 2'b01));

endmodule

bind mc_ctrl_fsm mcc_checker #(
  .OPC_W(OPC_W), .OP_R(OP_R), .OP_LD(OP_LD),
  .OP_ST(OP_ST), .OP_BEQ(OP_BEQ), .OP_J(OP_J)
) u_mcc_checker (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .opcode     (opcode),
  .ill_hint   (ill_hint),
  .ovf        (ovf),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .ir_we      (ir_we),
  .alu_b_sel  (alu_b_sel),
  .pc_we      (pc_we),
  .pc_we_cond (pc_we_cond),
  .pc_src     (pc_src),
  .dst_sel    (dst_sel),
  .rf_we      (rf_we),
  .epc_we     (epc_we),
  .cause_we   (cause_we),
  .cause_code (cause_code),
  .vec_sel    (vec_sel)
);

// File: tb/tb_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_mc_ctrl_fsm;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       ill_hint;
  logic       ovf;
  logic       mem_rd, mem_wr, addr_sel, ir_we, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic       pc_we, pc_we_cond, dst_sel, rf_we, wb_sel;
  logic       epc_we, cause_we, cause_code, vec_sel, kmode_set, intr_off;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mc_ctrl_fsm dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .ill_hint(ill_hint), .ovf(ovf),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_src(pc_src),
    .dst_sel(dst_sel), .rf_we(rf_we), .wb_sel(wb_sel),
    .epc_we(epc_we), .cause_we(cause_we), .cause_code(cause_code),
    .vec_sel(vec_sel), .kmode_set(kmode_set), .intr_off(intr_off)
  );

  // Field order: rd wr iord irw asa asb aop pcw pcc pcs rdst rfw m2r epcw cw cc vs ks id
  function automatic logic [22:0] ctl(
    input logic rd, input logic wr, input logic iord, input logic irw,
    input logic asa, input logic [1:0] asb, input logic [1:0] aop,
    input logic pcw, input logic pcc, input logic [1:0] pcs,
    input logic rdst, input logic rfw, input logic m2r,
    input logic epcw, input logic cw, input logic cc,
    input logic vs, input logic ks, input logic id);
    return {rd, wr, iord, irw, asa, asb, aop, pcw, pcc, pcs,
            rdst, rfw, m2r, epcw, cw, cc, vs, ks, id};
  endfunction

  logic [22:0] act;
  assign act = {mem_rd, mem_wr, addr_sel, ir_we, alu_a_sel, alu_b_sel, alu_op,
                pc_we, pc_we_cond, pc_src, dst_sel, rf_we, wb_sel,
                epc_we, cause_we, cause_code, vec_sel, kmode_set, intr_off};

  logic [22:0] E_FETCH, E_DEC, E_MADDR, E_MRD, E_LDWB, E_MWR,
               E_REXE, E_RWB, E_RWB_OVF, E_BEQ, E_JMP, E_XUND, E_XOVF;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_ctl(input string req, input string what, input logic [22:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; opcode = 6'h00; ill_hint = 1'b0; ovf = 1'b0;
    #1;
    expect_ctl("R1", "outputs in reset", E_FETCH);
    repeat (3) step();
    expect_ctl("R2", "fetch during reset", E_FETCH);
    rst_n = 1'b1;
    step();
    expect_ctl("R1", "hold after release edge 1", E_FETCH);
    step();
    expect_ctl("R1", "hold after release edge 2", E_FETCH);
  endtask

  task automatic t_load(input logic ovf_noise);
    opcode = 6'h23; ovf = ovf_noise;
    expect_ctl("R2", "load fetch", E_FETCH);
    step(); expect_ctl("R3", "load decode", E_DEC);
    step(); expect_ctl("R4", "load addr", E_MADDR);
    step(); expect_ctl("R4", "load read", E_MRD);
    step(); expect_ctl("R5", "load writeback", E_LDWB);
    step(); expect_ctl("R5", "load back to fetch", E_FETCH);
    if (ovf_noise) expect_ctl("R13", "ovf ignored in load", E_FETCH);
    ovf = 1'b0;
  endtask

  task automatic t_store(input logic ovf_noise);
    opcode = 6'h2B; ovf = ovf_noise;
    expect_ctl("R2", "store fetch", E_FETCH);
    step(); expect_ctl("R3", "store decode", E_DEC);
    step(); expect_ctl("R4", "store addr", E_MADDR);
    step(); expect_ctl("R4", "store write", E_MWR);
    step(); expect_ctl("R13", "store back to fetch", E_FETCH);
    ovf = 1'b0;
  endtask

  task automatic t_rtype(input logic ovf_at_wb);
    opcode = 6'h00; ovf = 1'b0;
    step(); expect_ctl("R3", "rtype decode", E_DEC);
    step(); expect_ctl("R6", "rtype execute", E_REXE);
    step();
    ovf = ovf_at_wb;
    #1;
    if (ovf_at_wb) begin
      expect_ctl("R8", "rtype wb with ovf", E_RWB_OVF);
      step(); expect_ctl("R8", "overflow exception", E_XOVF);
      ovf = 1'b0;
      step(); expect_ctl("R12", "fetch after overflow trap", E_FETCH);
    end else begin
      expect_ctl("R7", "rtype wb", E_RWB);
      step(); expect_ctl("R7", "rtype back to fetch", E_FETCH);
    end
    ovf = 1'b0;
  endtask

  task automatic t_branch(input logic ovf_noise);
    opcode = 6'h04; ovf = ovf_noise;
    step(); expect_ctl("R3", "beq decode", E_DEC);
    step(); expect_ctl("R9", "beq", E_BEQ);
    step(); expect_ctl("R9", "beq back to fetch", E_FETCH);
    ovf = 1'b0;
  endtask

  task automatic t_jump(input logic ovf_noise);
    opcode = 6'h02; ovf = ovf_noise;
    step(); expect_ctl("R3", "jump decode", E_DEC);
    step(); expect_ctl("R10", "jump", E_JMP);
    step(); expect_ctl("R10", "jump back to fetch", E_FETCH);
    ovf = 1'b0;
  endtask

  task automatic t_undef(input logic [5:0] op, input logic hint);
    opcode = op; ill_hint = hint;
    step(); expect_ctl("R11", $sformatf("decode op %0h hint %0b", op, hint), E_DEC);
    step(); expect_ctl("R11", $sformatf("undef trap op %0h hint %0b", op, hint), E_XUND);
    ill_hint = 1'b0;
    step(); expect_ctl("R12", "fetch after undef trap", E_FETCH);
  endtask

  task automatic t_mid_reset();
    opcode = 6'h23;
    step(); step(); step();
    expect_ctl("R4", "load read before reset", E_MRD);
    #1 rst_n = 1'b0;
    #1 expect_ctl("R1", "async return to fetch", E_FETCH);
    @(negedge clk);
    rst_n = 1'b1;
    step(); expect_ctl("R1", "mid reset hold 1", E_FETCH);
    step(); expect_ctl("R1", "mid reset hold 2", E_FETCH);
    step(); expect_ctl("R1", "decode on third edge", E_DEC);
    step(); expect_ctl("R4", "load resumes after reset", E_MADDR);
    step(); step(); step();
    expect_ctl("R5", "load completes", E_FETCH);
  endtask

  initial begin
    E_FETCH   = ctl(1,0,0,1, 0,2'b01,2'b00, 1,0,2'b00, 0,0,0, 0,0,0, 0,0,0);
    E_DEC     = ctl(0,0,0,0, 0,2'b11,2'b00, 0,0,2'b00, 0,0,0, 0,0,0, 0,0,0);
    E_MADDR   = ctl(0,0,0,0, 1,2'b10,2'b00, 0,0,2'b00, 0,0,0, 0,0,0, 0,0,0);
    E_MRD     = ctl(1,0,1,0, 0,2'b00,2'b00, 0,0,2'b00, 0,0,0, 0,0,0, 0,0,0);
    E_LDWB    = ctl(0,0,0,0, 0,2'b00,2'b00, 0,0,2'b00, 0,1,1, 0,0,0, 0,0,0);
    E_MWR     = ctl(0,1,1,0, 0,2'b00,2'b00, 0,0,2'b00, 0,0,0, 0,0,0, 0,0,0);
    E_REXE    = ctl(0,0,0,0, 1,2'b00,2'b10, 0,0,2'b00, 0,0,0, 0,0,0, 0,0,0);
    E_RWB     = ctl(0,0,0,0, 0,2'b00,2'b00, 0,0,2'b00, 1,1,0, 0,0,0, 0,0,0);
    E_RWB_OVF = ctl(0,0,0,0, 0,2'b00,2'b00, 0,0,2'b00, 1,0,0, 0,0,0, 0,0,0);
    E_BEQ     = ctl(0,0,0,0, 1,2'b00,2'b01, 0,1,2'b01, 0,0,0, 0,0,0, 0,0,0);
    E_JMP     = ctl(0,0,0,0, 0,2'b00,2'b00, 1,0,2'b10, 0,0,0, 0,0,0, 0,0,0);
    E_XUND    = ctl(0,0,0,0, 0,2'b01,2'b01, 1,0,2'b11, 0,0,0, 1,1,0, 1,1,1);
    E_XOVF    = ctl(0,0,0,0, 0,2'b01,2'b01, 1,0,2'b11, 0,0,0, 1,1,1, 1,1,1);

    t_reset();
    t_load(1'b0);
    t_load(1'b1);
    t_store(1'b1);
    t_rtype(1'b0);
    t_rtype(1'b1);
    t_branch(1'b1);
    t_jump(1'b1);
    t_undef(6'h3F, 1'b0);
    t_undef(6'h22, 1'b0);
    t_undef(6'h03, 1'b0);
    t_undef(6'h23, 1'b1);
    t_rtype(1'b0);
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule